// File: doc/BRIEF.md
# Shadowed SRAM with Store/Recall Sequencing

This block is a small static RAM with a second, nonvolatile-style copy of every word sitting behind it. A host reads and writes the RAM through an active-low select and an active-low write strobe, all on one clock. Two active-low controls copy the whole array in one direction or the other. A save pulse copies RAM into the shadow copy. A restore level copies the shadow copy back into RAM. Both transfers visit one word per clock cycle and then return to idle.

The block decides which request wins when several arrive together. It filters out short save pulses. It restores the RAM by itself each time the supply-good input rises. It then holds off reads for a short window and writes and saves for a longer one. If a save starts in the same cycle as a host write, that word is marked undefined. Each word carries a flag bit for this, and the flag travels with the word through both transfers.

Top module: `nvs_shadow_sram`

## Requirements
- R1: When idle, with `sel_n`=0, `wr_n`=1 and the read window open, the next cycle shows `rd_en`=1 with the word at `addr` on `rd_data`/`rd_bad`. In any other cycle `rd_en`, `rd_data` and `rd_bad` are 0.
- R2: When idle, with `sel_n`=0, `wr_n`=0 and the write window open, `wr_data` is written to `addr` and that word's undefined flag is cleared. There is no output that cycle.
- R3: While `busy` is high, `rd_en` stays 0 and host writes and `restore_n` have no effect.
- R4: A save starts after `save_n` has been sampled low for `SAVE_MIN` consecutive idle cycles while armed. `busy` then stays high for exactly 2^`ADDR_W` cycles, even if `save_n` has already returned high.
- R5: A `save_n` low run shorter than `SAVE_MIN` cycles starts nothing.
- R6: When idle and past the write window, `restore_n`=0 starts a restore lasting 2^`ADDR_W` cycles. The restore wins over host access and over a pending save, and `restore_n`=0 resets the save filter.
- R7: If a save starts in a cycle with a host write request, the write is dropped and that word's flag is set in RAM. The save then copies the set flag into the shadow copy, so reads show `rd_bad`=1 after the save and again after a restore.
- R8: In the first cycle `pwr_ok` is sampled high after being low, a restore begins with no request.
- R9: Reads are refused until `pwr_ok` has been sampled high on `READ_HOLD` edges.
- R10: Writes, saves and restores are refused until `pwr_ok` has been sampled high on `WRITE_HOLD` edges.
- R11: While `pwr_ok` is low, and during reset, `busy` and `rd_en` are 0 and nothing is accepted.
- R12: A save is armed only by `save_n` being sampled high after the write window has opened. Holding `save_n` low through power-up starts no save. After a save, `save_n` must return high before another save can start.
- R13: A host write to a word whose flag is set clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| pwr_ok | input | 1 | Supply-good indication |
| sel_n | input | 1 | Active-low host select |
| wr_n | input | 1 | Host write strobe, low = write, high = read |
| save_n | input | 1 | Active-low request to copy RAM into the shadow copy |
| restore_n | input | 1 | Active-low request to copy the shadow copy into RAM |
| addr | input | ADDR_W | Host word address |
| wr_data | input | DATA_W | Host write data |
| rd_data | output | DATA_W | Read data, zero when not valid |
| rd_bad | output | 1 | Read word is marked undefined |
| rd_en | output | 1 | Read data valid (output-enable) |
| busy | output | 1 | A save or restore is running |

## Verification
The save filter is driven with a two-cycle low run, which must not start a save, and with an exact `SAVE_MIN` run, which must start one. This separates the length threshold from plain edge detection. Saves and restores are surrounded by host writes, reads and opposing requests. Restoring after overwriting RAM shows whether the shadow copy really holds the saved data. A save that lands on a write shows whether the undefined mark survives both directions, and a later write shows that it can be cleared. Two power-ups, one with `save_n` held low and one with host traffic timed between the two windows, tell the read window, the write window and arming apart. A long random mix is then compared every cycle against a behavioural model.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

    // Sequencer states of the shadowed SRAM controller.
    typedef enum logic [1:0] {
        ST_OFF     = 2'd0,
        ST_IDLE    = 2'd1,
        ST_SAVE    = 2'd2,
        ST_RESTORE = 2'd3
    } nvs_state_e;

endpackage

// File: rtl/nvs_lockout.sv
// Counts edges since supply-good rose and opens the read and write windows.
module nvs_lockout #(
    parameter int READ_HOLD  = 64,
    parameter int WRITE_HOLD = 2048
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_ok,
    output logic rd_ok,
    output logic wr_ok
);
    localparam int CNT_W = $clog2(WRITE_HOLD + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!pwr_ok) begin
            cnt_d = '0;
        end else if (cnt_q != CNT_W'(WRITE_HOLD)) begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign rd_ok = (cnt_q >= CNT_W'(READ_HOLD));
    assign wr_ok = (cnt_q >= CNT_W'(WRITE_HOLD));

    // R10: the write window never opens ahead of the read window (READ_HOLD <= WRITE_HOLD).
    p_lock_order_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ok |-> rd_ok);

    generate
        if (WRITE_HOLD > 0) begin : g_drop_chk
            // R11: losing supply closes the write window on the next cycle.
            p_lock_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
                !pwr_ok |=> !wr_ok);
        end
    endgenerate
endmodule

// File: rtl/nvs_save_filter.sv
// Arms on a high save input, then requires SAVE_MIN consecutive low samples.
module nvs_save_filter #(
    parameter int SAVE_MIN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic active,
    input  logic wr_ok,
    input  logic save_n,
    input  logic restore_n,
    output logic fire
);
    localparam int FLT_W = $clog2(SAVE_MIN + 1);

    typedef struct packed {
        logic             armed;
        logic [FLT_W-1:0] run;
    } flt_t;

    flt_t flt_d, flt_q;

    always_comb begin
        flt_d = flt_q;
        fire  = 1'b0;
        if (clear) begin
            flt_d = '0;
        end else if (!active) begin
            flt_d.run = '0;
        end else if (save_n) begin
            flt_d.run   = '0;
            flt_d.armed = wr_ok;
        end else if (!restore_n || !flt_q.armed) begin
            flt_d.run = '0;
        end else if (flt_q.run == FLT_W'(SAVE_MIN - 1)) begin
            fire        = 1'b1;
            flt_d.run   = '0;
            flt_d.armed = 1'b0;
        end else begin
            flt_d.run = flt_q.run + FLT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flt_q <= '0;
        else        flt_q <= flt_d;
    end

    // R6: a low restore input always suppresses a save start.
    p_restore_blocks_save_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !restore_n |-> !fire);

    generate
        if (SAVE_MIN >= 2) begin : g_pulse_chk
            // R5: a start is only possible after the input was already low last cycle.
            p_pulse_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
                fire |-> !$past(save_n));
        end
    endgenerate
endmodule

// File: rtl/nvs_arrays.sv
// Working RAM and shadow copy; each word carries an undefined flag in its MSB.
module nvs_arrays #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic              host_poison,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              to_shadow,
    input  logic              to_ram,
    input  logic [ADDR_W-1:0] xfer_idx,
    output logic [DATA_W-1:0] rd_word,
    output logic              rd_bad
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W:0] ram_q    [DEPTH];
    logic [DATA_W:0] shadow_q [DEPTH];

    always_ff @(posedge clk) begin
        if (host_we)     ram_q[host_addr]         <= {1'b0, host_wdata};
        if (host_poison) ram_q[host_addr][DATA_W] <= 1'b1;
        if (to_ram)      ram_q[xfer_idx]          <= shadow_q[xfer_idx];
        if (to_shadow)   shadow_q[xfer_idx]       <= ram_q[xfer_idx];
    end

    assign rd_word = ram_q[host_addr][DATA_W-1:0];
    assign rd_bad  = ram_q[host_addr][DATA_W];

    // R3: host and sequencer never update the arrays in the same cycle.
    p_single_writer_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({host_we, host_poison, to_ram, to_shadow}));
endmodule

// File: rtl/nvs_shadow_sram.sv
module nvs_shadow_sram
    import nvs_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 4,
    parameter int SAVE_MIN   = 4,
    parameter int READ_HOLD  = 64,
    parameter int WRITE_HOLD = 2048
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_ok,
    input  logic              sel_n,
    input  logic              wr_n,
    input  logic              save_n,
    input  logic              restore_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_bad,
    output logic              rd_en,
    output logic              busy
);
    localparam logic [ADDR_W-1:0] LAST_IDX = '1;

    typedef struct packed {
        nvs_state_e        state;
        logic [ADDR_W-1:0] idx;
        logic              oe;
        logic [DATA_W-1:0] rdata;
        logic              rbad;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              rd_ok, wr_ok, fire;
    logic              host_we, host_poison, to_shadow, to_ram;
    logic [DATA_W-1:0] arr_word;
    logic              arr_bad;
    logic              idle_now, wr_req, rd_req;

    nvs_lockout #(
        .READ_HOLD (READ_HOLD),
        .WRITE_HOLD(WRITE_HOLD)
    ) u_lock (
        .clk   (clk),
        .rst_n (rst_n),
        .pwr_ok(pwr_ok),
        .rd_ok (rd_ok),
        .wr_ok (wr_ok)
    );

    assign idle_now = pwr_ok && (ctl_q.state == ST_IDLE);

    nvs_save_filter #(
        .SAVE_MIN(SAVE_MIN)
    ) u_filt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (!pwr_ok),
        .active   (idle_now),
        .wr_ok    (wr_ok),
        .save_n   (save_n),
        .restore_n(restore_n),
        .fire     (fire)
    );

    nvs_arrays #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_arr (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_we),
        .host_poison(host_poison),
        .host_addr  (addr),
        .host_wdata (wr_data),
        .to_shadow  (to_shadow),
        .to_ram     (to_ram),
        .xfer_idx   (ctl_q.idx),
        .rd_word    (arr_word),
        .rd_bad     (arr_bad)
    );

    assign wr_req = !sel_n && !wr_n && wr_ok;
    assign rd_req = !sel_n && wr_n && rd_ok;

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.oe    = 1'b0;
        ctl_d.rdata = '0;
        ctl_d.rbad  = 1'b0;
        host_we     = 1'b0;
        host_poison = 1'b0;
        to_shadow   = 1'b0;
        to_ram      = 1'b0;
        if (!pwr_ok) begin
            ctl_d.state = ST_OFF;
            ctl_d.idx   = '0;
        end else begin
            unique case (ctl_q.state)
                ST_OFF: begin
                    ctl_d.state = ST_RESTORE;
                    ctl_d.idx   = '0;
                end
                ST_RESTORE, ST_SAVE: begin
                    to_ram    = (ctl_q.state == ST_RESTORE);
                    to_shadow = (ctl_q.state == ST_SAVE);
                    if (ctl_q.idx == LAST_IDX) begin
                        ctl_d.state = ST_IDLE;
                        ctl_d.idx   = '0;
                    end else begin
                        ctl_d.idx = ctl_q.idx + 1'b1;
                    end
                end
                default: begin
                    if (!restore_n && wr_ok) begin
                        ctl_d.state = ST_RESTORE;
                        ctl_d.idx   = '0;
                    end else if (fire) begin
                        ctl_d.state = ST_SAVE;
                        ctl_d.idx   = '0;
                        host_poison = wr_req;
                    end else if (wr_req) begin
                        host_we = 1'b1;
                    end else if (rd_req) begin
                        ctl_d.oe    = 1'b1;
                        ctl_d.rdata = arr_word;
                        ctl_d.rbad  = arr_bad;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{state: ST_OFF, idx: '0, oe: 1'b0, rdata: '0, rbad: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign rd_data = ctl_q.rdata;
    assign rd_bad  = ctl_q.rbad;
    assign rd_en   = ctl_q.oe;
    assign busy    = (ctl_q.state == ST_SAVE) || (ctl_q.state == ST_RESTORE);

    // R3: no read data is presented while a transfer runs.
    p_quiet_when_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !rd_en);

    // R4: a save keeps running until its last word, whatever save_n does.
    p_save_runs_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_ok && ctl_q.state == ST_SAVE && ctl_q.idx != LAST_IDX)
        |=> (ctl_q.state == ST_SAVE));

    // R8: supply-good seen from the off state starts a restore at word zero.
    p_auto_restore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_ok && ctl_q.state == ST_OFF) |=> (busy && ctl_q.idx == '0));

    // R11: without supply nothing is busy or driven on the next cycle.
    p_off_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ok |=> (!busy && !rd_en));
endmodule

// File: tb/tb_nvs_shadow_sram.sv
module tb_nvs_shadow_sram;
    localparam int AW    = 4;
    localparam int DW    = 4;
    localparam int DEPTH = 1 << AW;
    localparam int SMIN  = 3;
    localparam int RH    = 24;
    localparam int WH    = 40;

    localparam int M_OFF = 0, M_IDLE = 1, M_SAVE = 2, M_REST = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pwr_ok = 1'b0;
    logic          sel_n = 1'b1;
    logic          wr_n = 1'b1;
    logic          save_n = 1'b0;
    logic          restore_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic          rd_bad, rd_en, busy;

    int errors = 0;
    int checks = 0;
    string phase = "R11 reset";

    always #10 clk = ~clk;

    nvs_shadow_sram #(
        .ADDR_W(AW), .DATA_W(DW), .SAVE_MIN(SMIN),
        .READ_HOLD(RH), .WRITE_HOLD(WH)
    ) dut (
        .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .sel_n(sel_n), .wr_n(wr_n),
        .save_n(save_n), .restore_n(restore_n), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .rd_bad(rd_bad), .rd_en(rd_en), .busy(busy)
    );

    // Behavioural reference: words are bad*16+data, -1 means unknown.
    int m_state = M_OFF, m_idx = 0, m_cnt = 0, m_run = 0;
    bit m_armed = 0, m_oe = 0;
    int m_rd = 0;
    int m_ram [DEPTH];
    int m_sh  [DEPTH];

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            m_ram[i] = -1;
            m_sh[i]  = -1;
        end
    end

    task automatic model_step();
        bit rd_open, wr_open, start_save, want_wr, want_rd;
        rd_open = (m_cnt >= RH);
        wr_open = (m_cnt >= WH);
        m_oe = 0;
        m_rd = 0;
        if (!pwr_ok) begin
            m_state = M_OFF; m_idx = 0; m_armed = 0; m_run = 0;
        end else if (m_state == M_OFF) begin
            m_state = M_REST; m_idx = 0; m_run = 0;
        end else if (m_state == M_REST || m_state == M_SAVE) begin
            if (m_state == M_REST) m_ram[m_idx] = m_sh[m_idx];
            else                   m_sh[m_idx]  = m_ram[m_idx];
            m_run = 0;
            if (m_idx == DEPTH - 1) begin m_state = M_IDLE; m_idx = 0; end
            else m_idx++;
        end else begin
            start_save = 0;
            if (save_n) begin m_run = 0; m_armed = wr_open; end
            else if (!restore_n || !m_armed) m_run = 0;
            else if (m_run == SMIN - 1) begin start_save = 1; m_run = 0; m_armed = 0; end
            else m_run++;
            want_wr = !sel_n && !wr_n && wr_open;
            want_rd = !sel_n && wr_n && rd_open;
            if (!restore_n && wr_open) begin
                m_state = M_REST; m_idx = 0;
            end else if (start_save) begin
                m_state = M_SAVE; m_idx = 0;
                if (want_wr) m_ram[addr] = 16;
            end else if (want_wr) begin
                m_ram[addr] = int'(wr_data);
            end else if (want_rd) begin
                m_oe = 1;
                m_rd = m_ram[addr];
            end
        end
        m_cnt = pwr_ok ? ((m_cnt < WH) ? m_cnt + 1 : m_cnt) : 0;
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_state = M_OFF; m_idx = 0; m_cnt = 0; m_run = 0;
            m_armed = 0; m_oe = 0; m_rd = 0;
        end else begin
            model_step();
        end
    end

    task automatic check(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s actual=%0d expected=%0d", phase, what, act, exp);
        end
    endtask

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        check(busy == ((m_state == M_SAVE) || (m_state == M_REST)), "busy", busy,
              int'((m_state == M_SAVE) || (m_state == M_REST)));
        check(rd_en == m_oe, "rd_en", rd_en, m_oe);
        if (!m_oe) begin
            check(rd_data == 0 && !rd_bad, "idle data", int'({rd_bad, rd_data}), 0);
        end else if (m_rd >= 0) begin
            check(rd_bad == m_rd[4], "rd_bad", rd_bad, m_rd[4]);
            if (!m_rd[4]) check(int'(rd_data) == m_rd[3:0], "rd_data", rd_data, m_rd[3:0]);
        end
    end

    function automatic int pat(input int a);
        return (a * 5 + 3) & 15;
    endfunction

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_wr(input int a, input int d);
        sel_n = 0; wr_n = 0; addr = AW'(a); wr_data = DW'(d);
        @(negedge clk);
        sel_n = 1; wr_n = 1;
    endtask

    task automatic host_rd(input int a, output int d, output bit bad, output bit en);
        sel_n = 0; wr_n = 1; addr = AW'(a);
        @(negedge clk);
        d = int'(rd_data); bad = rd_bad; en = rd_en;
        sel_n = 1;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not end actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int d, n;
        bit bad, en;
        cyc(3);
        check(!busy && !rd_en, "R11 reset outputs", int'({busy, rd_en}), 0);
        rst_n = 1;
        cyc(3);
        // First power-up with save_n held low (R12), read window probe (R9).
        phase = "R8 R12 power-up";
        pwr_ok = 1;
        cyc(1);
        check(busy == 1, "R8 auto restore", busy, 1);
        cyc(19);
        phase = "R9 read hold";
        host_rd(0, d, bad, en);
        check(en == 0, "R9 read refused", en, 0);
        phase = "R12 held low";
        cyc(40);
        check(busy == 0, "R12 no save", busy, 0);
        save_n = 1;
        cyc(2);
        // Fill and read back (R1 R2).
        phase = "R1 R2 host access";
        for (int a = 0; a < DEPTH; a++) host_wr(a, pat(a));
        for (int a = 0; a < DEPTH; a++) begin
            host_rd(a, d, bad, en);
            check(en && d == pat(a) && !bad, "R2 readback", d, pat(a));
        end
        // Short pulse (R5).
        phase = "R5 short pulse";
        save_n = 0; cyc(2); save_n = 1; cyc(3);
        check(busy == 0, "R5 no save", busy, 0);
        // Clean save with length measurement (R4).
        phase = "R4 save";
        save_n = 0; cyc(3); save_n = 1;
        n = 0;
        while (busy) begin n++; @(negedge clk); end
        check(n == DEPTH, "R4 save length", n, DEPTH);
        // Save with interference (R3).
        phase = "R3 busy ignores host";
        cyc(1);
        save_n = 0; cyc(3); save_n = 1;
        host_wr(2, 0);
        restore_n = 0; cyc(1); restore_n = 1;
        host_rd(4, d, bad, en);
        check(en == 0, "R3 read refused", en, 0);
        wait_idle();
        cyc(1);
        host_rd(2, d, bad, en);
        check(d == pat(2), "R3 write ignored", d, pat(2));
        // Overwrite then restore (R6).
        phase = "R6 restore";
        for (int a = 0; a < DEPTH; a++) host_wr(a, (~pat(a)) & 15);
        restore_n = 0; cyc(1); restore_n = 1;
        n = 0;
        while (busy) begin n++; @(negedge clk); end
        check(n == DEPTH, "R6 restore length", n, DEPTH);
        for (int a = 0; a < DEPTH; a++) begin
            host_rd(a, d, bad, en);
            check(d == pat(a), "R6 restored word", d, pat(a));
        end
        restore_n = 0; save_n = 0; cyc(2); restore_n = 1; cyc(3); save_n = 1;
        wait_idle();
        cyc(3);
        check(busy == 0, "R6 save suppressed", busy, 0);
        // Save colliding with a write (R7), then clear (R13).
        phase = "R7 collision";
        save_n = 0; cyc(2);
        sel_n = 0; wr_n = 0; addr = 5; wr_data = 0;
        cyc(1);
        sel_n = 1; wr_n = 1; save_n = 1;
        wait_idle();
        host_rd(5, d, bad, en);
        check(bad == 1, "R7 ram word undefined", bad, 1);
        restore_n = 0; cyc(1); restore_n = 1;
        wait_idle();
        host_rd(5, d, bad, en);
        check(bad == 1, "R7 shadow word undefined", bad, 1);
        phase = "R13 clear flag";
        host_wr(5, 9);
        host_rd(5, d, bad, en);
        check(!bad && d == 9, "R13 flag cleared", int'({bad, 4'(d)}), 9);
        // Power cycle (R11 R8 R9 R10).
        phase = "R11 supply low";
        pwr_ok = 0; cyc(2);
        host_rd(1, d, bad, en);
        check(en == 0 && busy == 0, "R11 nothing accepted", int'({en, busy}), 0);
        cyc(1);
        phase = "R8 R10 second power-up";
        pwr_ok = 1; cyc(1);
        check(busy == 1, "R8 auto restore", busy, 1);
        cyc(25);
        host_rd(7, d, bad, en);
        check(en == 1 && d == pat(7), "R9 read open", d, pat(7));
        host_wr(3, 0);
        save_n = 0; cyc(5); save_n = 1;
        check(busy == 0, "R10 save refused", busy, 0);
        host_rd(3, d, bad, en);
        check(en == 1 && d == pat(3), "R10 write refused", d, pat(3));
        cyc(10);
        // Random mix compared every cycle.
        phase = "R1 R2 R4 R6 random mix";
        for (int k = 0; k < 3000; k++) begin
            int unsigned r;
            r = $urandom;
            pwr_ok = (r % 700) != 0;
            sel_n = r[1]; wr_n = r[2];
            addr = r[11:8]; wr_data = r[15:12];
            if (r[20:17] == 0) save_n = ~save_n;
            restore_n = (r[30:24] != 0);
            @(negedge clk);
        end
        sel_n = 1; wr_n = 1; save_n = 1; restore_n = 1; pwr_ok = 1;
        cyc(DEPTH + 4);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule